// File: doc/BRIEF.md
# Polled Memory-Mapped Byte Port

This block lets a processor exchange bytes with a device through plain loads and stores. It sits on the processor's load/store bus and claims every address from 0xFFFF0000 up to 0xFFFFFFFF. Inside that window it offers four word-aligned registers: a status/control word and a data word for the receive direction, and the same pair for the transmit direction. The device side raises a per-direction ready flag when a received byte is waiting or when the transmit path has room. Software either spins on the status word until the flag is up, or enables the per-direction interrupt and waits for the level-sensitive request.

Reading the receive data word takes the waiting byte and drops the receive flag. Writing the transmit data word while the transmit flag is up hands the byte to the device, drops the flag and emits a one-cycle launch pulse. Device-side events always win over a same-cycle processor-side clear, so no arrival or free slot is lost. Read data is combinational in the same cycle as the load; all state changes occur at the following clock edge.

Top module: `mmio_poll_port`

## Requirements
- R1: A load or store whose address lies below 0xFFFF0000 returns zero on busRdata and changes no state, even when its low 16 bits match a register offset.
- R2: Inside the window, offset 0x0 is receive status, 0x4 receive data, 0x8 transmit status, 0xC transmit data; status words carry ready in bit 0 and interrupt enable in bit 1, data words carry the byte in bits 7:0, all other bits read zero, and busRdata is zero when no load is presented.
- R3: A rxStrobe pulse captures rxByte into the receive data word and sets receive ready (overwriting any unread byte); a txFree pulse sets transmit ready.
- R4: A load from receive data clears receive ready; a store to transmit data while transmit ready is 1 clears transmit ready, stores the byte (readable at 0xC) and raises txLaunch for exactly the next cycle with that byte on txByte.
- R5: A store to transmit data while transmit ready is 0 is ignored: no txLaunch, and the transmit data word keeps its old value.
- R6: A load from receive data while receive ready is 0 returns the last captured byte and changes no state.
- R7: When a device-side set and a processor-side clear of the same ready flag fall in one cycle, the flag ends up set.
- R8: irq is high exactly while (receive ready AND receive enable) OR (transmit ready AND transmit enable).
- R9: Loads from window offsets other than the four registers return zero, and stores to them change no state.
- R10: A store to a status word updates only its enable bit; the ready bit cannot be written by software.
- R11: After reset both ready flags, both enables and both data words are zero, and irq and txLaunch are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 32 | Byte address of the current load or store |
| busRead | input | 1 | Load request this cycle |
| busWrite | input | 1 | Store request this cycle |
| busWdata | input | 32 | Store data |
| busRdata | output | 32 | Load data, valid in the same cycle as busRead |
| rxStrobe | input | 1 | Device pulse: a received byte is on rxByte |
| rxByte | input | 8 | Received byte |
| txFree | input | 1 | Device pulse: transmit path can take a byte |
| txLaunch | output | 1 | One-cycle pulse: byte on txByte handed to the device |
| txByte | output | 8 | Last byte accepted for transmission |
| irq | output | 1 | Level-sensitive interrupt request |

## Verification
The assertions take for granted that the processor never presents a load and a store in the same cycle, and that the device pulses are single-cycle events sampled at the clock edge. The stimulus keeps to this by choosing one bus operation (load, store or idle) per cycle and driving every input at the falling edge. Random traffic covers mapped offsets, unmapped and misaligned window offsets and out-of-window aliases, with directed sequences for the same-cycle set/clear collisions, ignored stores and repeated loads of an empty receive register.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;

  // Bit positions inside a status/control word
  localparam int READY_BIT = 0;
  localparam int IE_BIT    = 1;

  // Register offsets inside the window (sequence decoded by software)
  localparam int OFS_RX_STAT = 'h0;
  localparam int OFS_RX_DATA = 'h4;
  localparam int OFS_TX_STAT = 'h8;
  localparam int OFS_TX_DATA = 'hC;

  localparam int NUM_CHAN = 2;
  localparam int CH_RX    = 0;
  localparam int CH_TX    = 1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RX_STAT,
    SEL_RX_DATA,
    SEL_TX_STAT,
    SEL_TX_DATA
  } regSelT;

  // Strobes from decode control to the datapath
  typedef struct packed {
    logic popRx;    // load of receive data
    logic pushTx;   // store to transmit data (not yet gated by ready)
    logic ctlRxWr;  // store to receive status
    logic ctlTxWr;  // store to transmit status
  } portStrobeT;

endpackage

// File: rtl/mmio_port_ctrl.sv
module mmio_port_ctrl
  import mmio_port_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          WIN_LOG2 = 16,
  parameter logic [31:0] WIN_BASE = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  output regSelT            rdSel,
  output portStrobeT        strobe
);

  localparam int HI_W = ADDR_W - WIN_LOG2;

  logic [HI_W-1:0]     baseHi;
  logic [WIN_LOG2-1:0] offset;
  logic                inWindow;
  regSelT              hitSel;

  assign baseHi   = WIN_BASE[ADDR_W-1:WIN_LOG2];
  assign offset   = busAddr[WIN_LOG2-1:0];
  assign inWindow = (busAddr[ADDR_W-1:WIN_LOG2] == baseHi);

  always_comb begin
    hitSel = SEL_NONE;
    if (inWindow) begin
      if (offset == WIN_LOG2'(OFS_RX_STAT))      hitSel = SEL_RX_STAT;
      else if (offset == WIN_LOG2'(OFS_RX_DATA)) hitSel = SEL_RX_DATA;
      else if (offset == WIN_LOG2'(OFS_TX_STAT)) hitSel = SEL_TX_STAT;
      else if (offset == WIN_LOG2'(OFS_TX_DATA)) hitSel = SEL_TX_DATA;
    end
  end

  assign rdSel = busRead ? hitSel : SEL_NONE;

  always_comb begin
    strobe         = '0;
    strobe.popRx   = busRead  && (hitSel == SEL_RX_DATA);
    strobe.pushTx  = busWrite && (hitSel == SEL_TX_DATA);
    strobe.ctlRxWr = busWrite && (hitSel == SEL_RX_STAT);
    strobe.ctlTxWr = busWrite && (hitSel == SEL_TX_STAT);
  end

endmodule

// File: rtl/mmio_port_flag.sv
module mmio_port_flag (
  input  logic clk,
  input  logic rstN,
  input  logic setEv,
  input  logic clrEv,
  input  logic ieWr,
  input  logic ieVal,
  output logic ready,
  output logic ie
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ready <= 1'b0;
      ie    <= 1'b0;
    end else begin
      // device-side set has priority over a processor-side clear
      if (setEv)      ready <= 1'b1;
      else if (clrEv) ready <= 1'b0;
      if (ieWr)       ie    <= ieVal;
    end
  end

endmodule

// File: rtl/mmio_port_dp.sv
module mmio_port_dp
  import mmio_port_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  regSelT              rdSel,
  input  portStrobeT          strobe,
  input  logic [BUS_W-1:0]    busWdata,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                rxStrobe,
  input  logic [DATA_W-1:0]   rxByte,
  input  logic                txFree,
  output logic                txLaunch,
  output logic [DATA_W-1:0]   txByte,
  output logic                irq,
  output logic [NUM_CHAN-1:0] chanReady,
  output logic [NUM_CHAN-1:0] chanIe
);

  localparam int PAD_W = BUS_W - DATA_W;
  localparam int STAT_PAD_W = BUS_W - 2;

  logic [NUM_CHAN-1:0] setEv, clrEv, ieWr;
  logic [DATA_W-1:0]   rxData, txData;
  logic                txAccept;

  assign txAccept = strobe.pushTx & chanReady[CH_TX];

  assign setEv[CH_RX] = rxStrobe;
  assign setEv[CH_TX] = txFree;
  assign clrEv[CH_RX] = strobe.popRx;
  assign clrEv[CH_TX] = txAccept;
  assign ieWr[CH_RX]  = strobe.ctlRxWr;
  assign ieWr[CH_TX]  = strobe.ctlTxWr;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    mmio_port_flag uFlag (
      .clk   (clk),
      .rstN  (rstN),
      .setEv (setEv[c]),
      .clrEv (clrEv[c]),
      .ieWr  (ieWr[c]),
      .ieVal (busWdata[IE_BIT]),
      .ready (chanReady[c]),
      .ie    (chanIe[c])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      txData   <= '0;
      txLaunch <= 1'b0;
    end else begin
      if (rxStrobe) rxData <= rxByte;
      if (txAccept) txData <= busWdata[DATA_W-1:0];
      txLaunch <= txAccept;
    end
  end

  assign txByte = txData;
  assign irq    = |(chanReady & chanIe);

  always_comb begin
    unique case (rdSel)
      SEL_RX_STAT: busRdata = {{STAT_PAD_W{1'b0}}, chanIe[CH_RX], chanReady[CH_RX]};
      SEL_RX_DATA: busRdata = {{PAD_W{1'b0}}, rxData};
      SEL_TX_STAT: busRdata = {{STAT_PAD_W{1'b0}}, chanIe[CH_TX], chanReady[CH_TX]};
      SEL_TX_DATA: busRdata = {{PAD_W{1'b0}}, txData};
      default:     busRdata = '0;
    endcase
  end

  // upper store bits have no destination
  logic unusedWdata;
  assign unusedWdata = ^busWdata[BUS_W-1:DATA_W];

endmodule

// File: rtl/mmio_poll_port.sv
module mmio_poll_port
  import mmio_port_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          BUS_W    = 32,
  parameter int          DATA_W   = 8,
  parameter int          WIN_LOG2 = 16,
  parameter logic [31:0] WIN_BASE = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic              rxStrobe,
  input  logic [DATA_W-1:0] rxByte,
  input  logic              txFree,
  output logic              txLaunch,
  output logic [DATA_W-1:0] txByte,
  output logic              irq
);

  regSelT              rdSel;
  portStrobeT          strobe;
  logic [NUM_CHAN-1:0] chanReady;
  logic [NUM_CHAN-1:0] chanIe;

  mmio_port_ctrl #(
    .ADDR_W   (ADDR_W),
    .WIN_LOG2 (WIN_LOG2),
    .WIN_BASE (WIN_BASE)
  ) uCtrl (
    .busAddr  (busAddr),
    .busRead  (busRead),
    .busWrite (busWrite),
    .rdSel    (rdSel),
    .strobe   (strobe)
  );

  mmio_port_dp #(
    .BUS_W  (BUS_W),
    .DATA_W (DATA_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .rdSel     (rdSel),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .rxStrobe  (rxStrobe),
    .rxByte    (rxByte),
    .txFree    (txFree),
    .txLaunch  (txLaunch),
    .txByte    (txByte),
    .irq       (irq),
    .chanReady (chanReady),
    .chanIe    (chanIe)
  );

endmodule

// File: rtl/mmio_port_chk.sv
module mmio_port_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          BUS_W    = 32,
  parameter logic [31:0] WIN_BASE = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRead,
  input logic              busWrite,
  input logic [BUS_W-1:0]  busRdata,
  input logic              rxStrobe,
  input logic              txFree,
  input logic              txLaunch,
  input logic              irq,
  input logic [1:0]        chanReady
);

  logic [ADDR_W-1:0] rxDataAddr, txDataAddr;
  logic              aboveBase;

  assign rxDataAddr = ADDR_W'(WIN_BASE) + ADDR_W'(4);
  assign txDataAddr = ADDR_W'(WIN_BASE) + ADDR_W'(12);
  assign aboveBase  = (busAddr >= ADDR_W'(WIN_BASE));

  assert_outside_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && !aboveBase) |-> (busRdata == '0));

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busRead |-> (busRdata == '0));

  assert_rx_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> chanReady[0]);

  assert_tx_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    txFree |=> chanReady[1]);

  assert_rx_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == rxDataAddr && !rxStrobe) |=> !chanReady[0]);

  assert_tx_launch_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == txDataAddr && chanReady[1]) |=> txLaunch);

  assert_tx_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busWrite && busAddr == txDataAddr && !chanReady[1]) |=> !txLaunch);

  assert_launch_cause_R4: assert property (@(posedge clk) disable iff (!rstN)
    txLaunch |-> $past(busWrite));

  assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRead && busAddr == rxDataAddr && !chanReady[0] && !rxStrobe) |=> !chanReady[0]);

  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (chanReady == 2'b00) |-> !irq);

  assert_one_op_input: assert property (@(posedge clk) disable iff (!rstN)
    !(busRead && busWrite));

endmodule

bind mmio_poll_port mmio_port_chk #(
  .ADDR_W   (ADDR_W),
  .BUS_W    (BUS_W),
  .WIN_BASE (WIN_BASE)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busRead   (busRead),
  .busWrite  (busWrite),
  .busRdata  (busRdata),
  .rxStrobe  (rxStrobe),
  .txFree    (txFree),
  .txLaunch  (txLaunch),
  .irq       (irq),
  .chanReady (chanReady)
);

// File: tb/mmio_poll_port_tb.sv
module mmio_poll_port_tb_top;

  localparam logic [31:0] BASE   = 32'hFFFF_0000;
  localparam logic [31:0] A_RXST = BASE + 32'h0;
  localparam logic [31:0] A_RXDT = BASE + 32'h4;
  localparam logic [31:0] A_TXST = BASE + 32'h8;
  localparam logic [31:0] A_TXDT = BASE + 32'hC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRead = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rxStrobe = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        txFree = 1'b0;
  logic        txLaunch;
  logic [7:0]  txByte;
  logic        irq;

  always #5 clk = ~clk;

  mmio_poll_port dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRead(busRead),
    .busWrite(busWrite), .busWdata(busWdata), .busRdata(busRdata),
    .rxStrobe(rxStrobe), .rxByte(rxByte), .txFree(txFree),
    .txLaunch(txLaunch), .txByte(txByte), .irq(irq)
  );

  int nChecks = 0;
  int nFails  = 0;

  // reference model state
  logic       mRxRdy = 0, mTxRdy = 0, mRxIe = 0, mTxIe = 0, mLaunch = 0;
  logic [7:0] mRxData = 0, mTxData = 0;

  // values sampled in the last step
  logic [31:0] lastRdata;
  logic        lastIrq, lastLaunch;
  logic [7:0]  lastTxByte;

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(input logic rd, input logic [31:0] a);
    if (!rd) return '0;
    case (a)
      A_RXST: return {30'd0, mRxIe, mRxRdy};
      A_RXDT: return {24'd0, mRxData};
      A_TXST: return {30'd0, mTxIe, mTxRdy};
      A_TXDT: return {24'd0, mTxData};
      default: return '0;
    endcase
  endfunction

  function automatic string tagFor(input logic [31:0] a);
    if (a < BASE) return "R1";
    if (a != A_RXST && a != A_RXDT && a != A_TXST && a != A_TXDT) return "R9";
    if (a == A_RXDT && !mRxRdy) return "R6";
    return "R2";
  endfunction

  task automatic step(input logic rd, input logic wr, input logic [31:0] a,
                      input logic [31:0] wd, input logic rx, input logic [7:0] rb,
                      input logic tf);
    logic acc;
    @(negedge clk);
    busRead = rd; busWrite = wr; busAddr = a; busWdata = wd;
    rxStrobe = rx; rxByte = rb; txFree = tf;
    #1;
    lastRdata = busRdata; lastIrq = irq; lastLaunch = txLaunch; lastTxByte = txByte;
    if (rstN) begin
      checkVal(tagFor(a), busRdata, expRead(rd, a));
      checkVal("R8", {31'd0, irq}, {31'd0, (mRxRdy & mRxIe) | (mTxRdy & mTxIe)});
      checkVal("R4", {31'd0, txLaunch}, {31'd0, mLaunch});
      if (mLaunch) checkVal("R4", {24'd0, txByte}, {24'd0, mTxData});
      // model update for the coming edge
      acc = wr && a == A_TXDT && mTxRdy;
      mLaunch = acc;
      if (rx) begin mRxRdy = 1; mRxData = rb; end
      else if (rd && a == A_RXDT) mRxRdy = 0;
      if (tf) mTxRdy = 1;
      else if (acc) mTxRdy = 0;
      if (acc) mTxData = wd[7:0];
      if (wr && a == A_RXST) mRxIe = wd[1];
      if (wr && a == A_TXST) mTxIe = wd[1];
    end
  endtask

  task automatic rd(input logic [31:0] a);
    step(1, 0, a, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    step(0, 1, a, d, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(10 * 200000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    logic [31:0] picks [8];
    void'($urandom(32'd20240611));
    picks = '{A_RXST, A_RXDT, A_TXST, A_TXDT,
              BASE + 32'h10, BASE + 32'h6, 32'h0000_1004, 32'h7FFF_000C};

    // R11: state in reset and right after release
    step(1, 0, A_RXST, 0, 0, 0, 0);
    checkVal("R11", {31'd0, lastIrq}, 0);
    @(negedge clk); rstN = 1;
    rd(A_RXST); checkVal("R11", lastRdata, 0);
    rd(A_TXDT); checkVal("R11", lastRdata, 0);
    checkVal("R11", {31'd0, lastLaunch}, 0);

    // R10: ready bit not writable, enable is
    wr(A_RXST, 32'h3);
    rd(A_RXST); checkVal("R10", lastRdata, 32'h2);

    // R3: arrival sets ready and captures byte; R8 irq follows
    step(0, 0, 0, 0, 1, 8'hA5, 0);
    rd(A_RXST); checkVal("R3", lastRdata, 32'h3);
    checkVal("R8", {31'd0, lastIrq}, 1);

    // R4: load clears ready
    rd(A_RXDT); checkVal("R4", lastRdata, 32'hA5);
    rd(A_RXST); checkVal("R4", lastRdata, 32'h2);
    checkVal("R8", {31'd0, lastIrq}, 0);

    // R6: empty load returns last byte, no change
    rd(A_RXDT); checkVal("R6", lastRdata, 32'hA5);
    rd(A_RXST); checkVal("R6", lastRdata, 32'h2);

    // R5: store while not ready is ignored
    wr(A_TXDT, 32'h5A);
    rd(A_TXDT); checkVal("R5", {31'd0, lastLaunch}, 0);
    checkVal("R5", lastRdata, 32'h0);

    // R4: accepted store launches next cycle
    step(0, 0, 0, 0, 0, 0, 1);
    wr(A_TXDT, 32'hFFFF_FF3C);
    rd(A_TXST); checkVal("R4", {31'd0, lastLaunch}, 1);
    checkVal("R4", {24'd0, lastTxByte}, 32'h3C);
    checkVal("R4", lastRdata, 32'h0);

    // R7: set wins over same-cycle clear on both channels
    step(0, 0, 0, 0, 1, 8'h22, 0);
    step(1, 0, A_RXDT, 0, 1, 8'h11, 0);
    checkVal("R7", lastRdata, 32'h22);
    rd(A_RXST); checkVal("R7", lastRdata, 32'h3);
    rd(A_RXDT); checkVal("R7", lastRdata, 32'h11);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 1, A_TXDT, 32'h77, 0, 0, 1);
    rd(A_TXST); checkVal("R7", lastRdata, 32'h1);

    // R9 / R1: stray stores leave the enable intact
    wr(BASE + 32'h10, 32'h0);
    wr(32'h0000_0000, 32'h0);
    rd(BASE + 32'h10); checkVal("R9", lastRdata, 0);
    rd(A_RXST); checkVal("R1", lastRdata[1], 1'b1);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      int kind = $urandom % 10;
      logic [31:0] a = picks[$urandom % 8];
      step(kind < 4, kind >= 4 && kind < 8, a, $urandom,
           ($urandom % 4) == 0, 8'($urandom), ($urandom % 4) == 0);
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule